// File: doc/BRIEF.md
# GPIO Port Controller with Atomic Clear/Set/Toggle Aliases

This block is a memory-mapped general-purpose I/O controller for one or more port groups of up to 32 pins each. For every pin it holds a direction bit, an output-value bit and a pull-enable bit. From these it derives four pin-side signals: an output enable, a drive level, a pull-up select and a pull-down select. Software reaches each group through a window of 0x80 bytes on a simple single-cycle register bus. The group index is taken from the address bits above bit 6.

The direction and output-value registers can each be written whole. They can also be changed through clear, set and toggle alias addresses that take a bit mask, so one write changes only the masked bits and no read-modify-write sequence is needed. The output-value register has two uses. For an output pin it gives the drive level. For an input pin with pulls enabled it chooses between pull-up and pull-down.

A write-protect input blocks every write to the direction and output-value registers, and the blocked access is answered with an error flag. Each bus request receives exactly one response, one cycle later.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, every direction, output-value and pull-enable bit is 0. All pin outputs are then 0, and no response is pending.
- R2: A write with op "write" replaces the whole register. The direction register is at in-group offset 0x00, the output value at 0x10 and the pull enables at 0x40. Group g occupies byte addresses 0x80*g to 0x80*g+0x7F.
- R3: A write to a clear alias (0x04 for direction, 0x14 for output value) forces the masked bits to 0. Bits that are 0 in the mask keep their value.
- R4: A write to a set alias (0x08 for direction, 0x18 for output value) forces the masked bits to 1. All other bits keep their value.
- R5: A write to a toggle alias (0x0C for direction, 0x1C for output value) inverts the masked bits. All other bits keep their value.
- R6: pin_oe equals the direction bit (1 = output). pin_level equals the output-value bit.
- R7: pin_pull_up is 1 only when the pin is an input (direction 0), its pull-enable bit is 1 and its output-value bit is 1. pin_pull_dn is the same except that the output-value bit is 0. Both are 0 for an output pin.
- R8: Every request gets rsp_valid in the next cycle. A read of any direct or alias address returns the current value of the underlying register. A read of an unmapped, misaligned (address bits 1:0 not 00) or out-of-range-group address returns 0. A write response carries rdata 0.
- R9: While wr_protect is 1, writes to the direction and output-value registers and to all of their aliases leave the registers unchanged and respond with rsp_err = 1. Reads, writes to the pull-enable register and unmapped writes respond with rsp_err = 0.
- R10: A write takes effect at the clock edge where it is presented. The new value is visible on the pin outputs in the cycle right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, one per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | PINS | Write data or alias mask |
| wr_protect | input | 1 | Blocks writes to direction and output-value registers |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_rdata | output | PINS | Read data |
| rsp_err | output | 1 | Blocked-write error flag |
| pin_oe | output | NUM_GROUPS*PINS | Per-pin output enable |
| pin_level | output | NUM_GROUPS*PINS | Per-pin drive level |
| pin_pull_up | output | NUM_GROUPS*PINS | Per-pin pull-up select |
| pin_pull_dn | output | NUM_GROUPS*PINS | Per-pin pull-down select |

## Verification
Two functions can meet in one cycle. The first is an alias write to direction or output value. The second is write protection, raised in that same cycle. The bench drives wr_protect randomly on about a quarter of the cycles and mixes it with directed cases where protection rises exactly as a set or toggle write is presented. It then judges the result on the next cycle: the pin outputs must be unchanged, rsp_err must be 1, and a pull-enable write made under the same protection must still land. A second overlap is also covered. A toggle of the output value can land while a pin has been switched to input with pulls enabled, and the bench checks that the pull select follows the new level in the very next cycle.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int WIN_LSB_W = 7;  // 0x80-byte window per group

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_CLR   = 2'd1,
    OP_SET   = 2'd2,
    OP_TGL   = 2'd3
  } alias_op_e;

  typedef enum logic [1:0] {
    RS_DIR  = 2'd0,
    RS_OUT  = 2'd1,
    RS_PULL = 2'd2,
    RS_NONE = 2'd3
  } reg_sel_e;

  // Decode an in-group offset into the addressed register.
  function automatic reg_sel_e decode_sel(input logic [WIN_LSB_W-1:0] off);
    reg_sel_e s;
    s = RS_NONE;
    if (off[1:0] == 2'b00) begin
      if (off[6:4] == 3'd0)                            s = RS_DIR;
      else if (off[6:4] == 3'd1)                       s = RS_OUT;
      else if (off[6:4] == 3'd4 && off[3:2] == 2'b00)  s = RS_PULL;
    end
    return s;
  endfunction

endpackage

// File: rtl/gpio_alias_apply.sv
module gpio_alias_apply
  import gpio_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] mask,
  input  alias_op_e    op,
  output logic [W-1:0] nxt
);

  always_comb begin
    unique case (op)
      OP_WRITE: nxt = mask;
      OP_CLR:   nxt = cur & ~mask;
      OP_SET:   nxt = cur | mask;
      OP_TGL:   nxt = cur ^ mask;
      default:  nxt = cur;
    endcase
  end

endmodule

// File: rtl/gpio_group.sv
module gpio_group
  import gpio_pkg::*;
#(
  parameter int PINS = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic            wp,
  input  reg_sel_e        sel,
  input  alias_op_e       op,
  input  logic [PINS-1:0] wdata,
  output logic [PINS-1:0] dir_q,
  output logic [PINS-1:0] out_q,
  output logic [PINS-1:0] pen_q
);

  logic [PINS-1:0] dir_nxt;
  logic [PINS-1:0] out_nxt;

  gpio_alias_apply #(.W(PINS)) u_dir_alias (
    .cur(dir_q), .mask(wdata), .op(op), .nxt(dir_nxt)
  );

  gpio_alias_apply #(.W(PINS)) u_out_alias (
    .cur(out_q), .mask(wdata), .op(op), .nxt(out_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
      out_q <= '0;
      pen_q <= '0;
    end else if (wr_en) begin
      if (sel == RS_DIR && !wp) dir_q <= dir_nxt;
      if (sel == RS_OUT && !wp) out_q <= out_nxt;
      if (sel == RS_PULL)       pen_q <= wdata;
    end
  end

  // R9
  wp_dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wp && sel != RS_PULL) |=> ($stable(dir_q) && $stable(out_q)));

  // R3
  out_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wp && sel == RS_OUT && op == OP_CLR) |=> ((out_q & $past(wdata)) == '0));

  // R4
  out_set_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wp && sel == RS_OUT && op == OP_SET) |=> ((out_q & $past(wdata)) == $past(wdata)));

  // R5
  dir_tgl_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wp && sel == RS_DIR && op == OP_TGL) |=> (dir_q == ($past(dir_q) ^ $past(wdata))));

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_pkg::*;
#(
  parameter int NUM_GROUPS = 2,
  parameter int PINS       = 32,
  parameter int ADDR_W     = 12
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_req,
  input  logic                       bus_we,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [PINS-1:0]            bus_wdata,
  input  logic                       wr_protect,
  output logic                       rsp_valid,
  output logic [PINS-1:0]            rsp_rdata,
  output logic                       rsp_err,
  output logic [NUM_GROUPS*PINS-1:0] pin_oe,
  output logic [NUM_GROUPS*PINS-1:0] pin_level,
  output logic [NUM_GROUPS*PINS-1:0] pin_pull_up,
  output logic [NUM_GROUPS*PINS-1:0] pin_pull_dn
);

  localparam int GRP_W = ADDR_W - WIN_LSB_W;

  logic [WIN_LSB_W-1:0] offs;
  logic [GRP_W-1:0]     grp_field;
  reg_sel_e             sel;
  alias_op_e            op;
  logic [NUM_GROUPS-1:0] grp_hit;
  logic [PINS-1:0]      dir_a [NUM_GROUPS];
  logic [PINS-1:0]      out_a [NUM_GROUPS];
  logic [PINS-1:0]      pen_a [NUM_GROUPS];
  logic [PINS-1:0]      rd_val;
  logic                 blocked;

  assign offs      = bus_addr[WIN_LSB_W-1:0];
  assign grp_field = bus_addr[ADDR_W-1:WIN_LSB_W];
  assign sel       = decode_sel(offs);
  assign op        = alias_op_e'(offs[3:2]);

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign grp_hit[g] = (grp_field == GRP_W'(g));

    gpio_group #(.PINS(PINS)) u_group (
      .clk   (clk),
      .rst   (rst),
      .wr_en (bus_req && bus_we && grp_hit[g]),
      .wp    (wr_protect),
      .sel   (sel),
      .op    (op),
      .wdata (bus_wdata),
      .dir_q (dir_a[g]),
      .out_q (out_a[g]),
      .pen_q (pen_a[g])
    );

    // Pin view: pulls only act on inputs.
    assign pin_oe[g*PINS +: PINS]      = dir_a[g];
    assign pin_level[g*PINS +: PINS]   = out_a[g];
    assign pin_pull_up[g*PINS +: PINS] = pen_a[g] & ~dir_a[g] &  out_a[g];
    assign pin_pull_dn[g*PINS +: PINS] = pen_a[g] & ~dir_a[g] & ~out_a[g];
  end

  always_comb begin
    rd_val = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (grp_hit[g]) begin
        unique case (sel)
          RS_DIR:  rd_val = dir_a[g];
          RS_OUT:  rd_val = out_a[g];
          RS_PULL: rd_val = pen_a[g];
          default: rd_val = '0;
        endcase
      end
    end
  end

  assign blocked = bus_req && bus_we && wr_protect && (|grp_hit)
                   && (sel == RS_DIR || sel == RS_OUT);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= bus_req;
      rsp_rdata <= (bus_req && !bus_we) ? rd_val : '0;
      rsp_err   <= blocked;
    end
  end

  // R8
  rsp_follow_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req |=> rsp_valid);

  // R8
  rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_req |=> (!rsp_valid && !rsp_err));

  // R9
  wp_err_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_we) |=> !rsp_err);

  // R7
  pull_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (((pin_pull_up | pin_pull_dn) & pin_oe) == '0) && ((pin_pull_up & pin_pull_dn) == '0));

endmodule

// File: tb/gpio_port_ctrl_tb.sv
module gpio_port_ctrl_tb;

  localparam int NG = 2;
  localparam int PW = 32;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0, we = 1'b0, wp = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [PW-1:0] wdata = '0;
  logic rsp_valid, rsp_err;
  logic [PW-1:0] rsp_rdata;
  logic [NG*PW-1:0] pin_oe, pin_level, pin_pull_up, pin_pull_dn;

  always #5 clk = ~clk;

  gpio_port_ctrl #(.NUM_GROUPS(NG), .PINS(PW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .bus_req(req), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .wr_protect(wp), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .pin_oe(pin_oe),
    .pin_level(pin_level), .pin_pull_up(pin_pull_up), .pin_pull_dn(pin_pull_dn)
  );

  // Reference model
  logic [PW-1:0] m_dir [NG];
  logic [PW-1:0] m_out [NG];
  logic [PW-1:0] m_pen [NG];
  logic m_valid, m_err;
  logic [PW-1:0] m_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req_tag, input string ctx,
                       input logic [NG*PW-1:0] act, input logic [NG*PW-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s (%s): actual %h expected %h", req_tag, ctx, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int g = 0; g < NG; g++) begin
      m_dir[g] = '0; m_out[g] = '0; m_pen[g] = '0;
    end
    m_valid = 0; m_err = 0; m_rdata = '0;
  endtask

  task automatic model_edge();
    int g, off, kind, opc;
    logic [PW-1:0] cur;
    g   = int'(addr) / 128;
    off = int'(addr) % 128;
    m_valid = req; m_err = 0; m_rdata = '0;
    if (!req) return;
    kind = 3;  // 0 dir, 1 out, 2 pull, 3 none
    if (g < NG && (off % 4) == 0) begin
      if (off < 16) kind = 0;
      else if (off < 32) kind = 1;
      else if (off == 64) kind = 2;
    end
    opc = (off / 4) % 4;
    if (!we) begin
      if (kind == 0) m_rdata = m_dir[g];
      else if (kind == 1) m_rdata = m_out[g];
      else if (kind == 2) m_rdata = m_pen[g];
      return;
    end
    if (kind == 2) begin
      m_pen[g] = wdata;
    end else if (kind < 2) begin
      if (wp) begin
        m_err = 1;
      end else begin
        cur = (kind == 0) ? m_dir[g] : m_out[g];
        case (opc)
          0: cur = wdata;
          1: cur = cur & ~wdata;
          2: cur = cur | wdata;
          default: cur = cur ^ wdata;
        endcase
        if (kind == 0) m_dir[g] = cur; else m_out[g] = cur;
      end
    end
  endtask

  task automatic compare(input string ctx);
    logic [NG*PW-1:0] e_oe, e_lv, e_pu, e_pd;
    for (int g = 0; g < NG; g++) begin
      e_oe[g*PW +: PW] = m_dir[g];
      e_lv[g*PW +: PW] = m_out[g];
      e_pu[g*PW +: PW] = m_pen[g] & ~m_dir[g] &  m_out[g];
      e_pd[g*PW +: PW] = m_pen[g] & ~m_dir[g] & ~m_out[g];
    end
    check(pin_oe === e_oe, "R6 oe", ctx, pin_oe, e_oe);
    check(pin_level === e_lv, "R6 level", ctx, pin_level, e_lv);
    check(pin_pull_up === e_pu, "R7 pull_up", ctx, pin_pull_up, e_pu);
    check(pin_pull_dn === e_pd, "R7 pull_dn", ctx, pin_pull_dn, e_pd);
    check(rsp_valid === m_valid, "R8 valid", ctx, {{(NG*PW-1){1'b0}}, rsp_valid},
          {{(NG*PW-1){1'b0}}, m_valid});
    if (m_valid) begin
      check(rsp_rdata === m_rdata, "R8 rdata", ctx, {{((NG-1)*PW){1'b0}}, rsp_rdata},
            {{((NG-1)*PW){1'b0}}, m_rdata});
      check(rsp_err === m_err, "R9 err", ctx, {{(NG*PW-1){1'b0}}, rsp_err},
            {{(NG*PW-1){1'b0}}, m_err});
    end
  endtask

  // One bus cycle: drive at negedge, model at posedge, compare at next negedge (R10).
  task automatic cyc(input logic r, input logic w, input int a, input logic [PW-1:0] d,
                     input logic p, input string ctx);
    req = r; we = w; addr = AW'(a); wdata = d; wp = p;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(ctx);
  endtask

  task automatic idle(input string ctx);
    cyc(0, 0, 0, '0, 0, ctx);
  endtask

  int offs_tbl [12] = '{0, 4, 8, 12, 16, 20, 24, 28, 64, 68, 32, 2};

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    compare("R1 reset state");
    idle("R1 reset idle");

    // R2 direct writes, distinct groups
    cyc(1, 1, 16'h000, 32'hF0F0_1234, 0, "R2 dir g0 write");
    cyc(1, 1, 16'h010, 32'hAAAA_5555, 0, "R2 out g0 write");
    cyc(1, 1, 16'h090, 32'h0000_FFFF, 0, "R2 out g1 write");
    cyc(1, 1, 16'h0C0, 32'hFFFF_FFFF, 0, "R2 pull g1 write");
    // R3 clear, R4 set, R5 toggle on both registers
    cyc(1, 1, 16'h014, 32'h0000_00FF, 0, "R3 out clear");
    cyc(1, 1, 16'h004, 32'hF000_0000, 0, "R3 dir clear");
    cyc(1, 1, 16'h018, 32'h8000_0001, 0, "R4 out set");
    cyc(1, 1, 16'h088, 32'h0000_000F, 0, "R4 dir g1 set");
    cyc(1, 1, 16'h01C, 32'hFFFF_0000, 0, "R5 out toggle");
    cyc(1, 1, 16'h08C, 32'h0000_0003, 0, "R5 dir g1 toggle");
    // R7 toggle of level on pulled inputs of g1
    cyc(1, 1, 16'h09C, 32'h0000_00F0, 0, "R7 toggle on pulled inputs");
    // R8 reads incl. aliases and unmapped
    cyc(1, 0, 16'h014, '0, 0, "R8 read out clear alias");
    cyc(1, 0, 16'h08C, '0, 0, "R8 read dir toggle alias");
    cyc(1, 0, 16'h0C0, '0, 0, "R8 read pull");
    cyc(1, 0, 16'h044, '0, 0, "R8 read unmapped");
    cyc(1, 0, 16'h012, '0, 0, "R8 read misaligned");
    cyc(1, 0, 16'h110, '0, 0, "R8 read group out of range");
    // R9 protection in same cycle as alias writes
    cyc(1, 1, 16'h018, 32'hFFFF_FFFF, 1, "R9 blocked out set");
    cyc(1, 1, 16'h08C, 32'hFFFF_FFFF, 1, "R9 blocked dir toggle");
    cyc(1, 1, 16'h040, 32'h1234_5678, 1, "R9 pull write under protect");
    cyc(1, 0, 16'h010, '0, 1, "R9 read under protect");
    cyc(1, 1, 16'h110, 32'h1, 1, "R9 unmapped write under protect");
    idle("R10 idle after writes");

    // Random mix
    for (int i = 0; i < 2000; i++) begin
      int a;
      a = ($urandom_range(0, 2) * 128) + offs_tbl[$urandom_range(0, 11)];
      cyc(1'($urandom_range(0, 4) != 0), 1'($urandom_range(0, 1)), a, $urandom(),
          1'($urandom_range(0, 3) == 0), "R2 random mix");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule